// File: doc/BRIEF.md
# Candidate Slice Buffer

This block takes trigger candidates that arrive one word per clock in a serial burst, one burst per bunch crossing. It turns each burst into a single wide slice word and keeps the most recent slices in a circular memory. The first six 32-bit words of a burst and their valid flags are retained. The seventh word is dropped. A burst-length error field and the crossing number are added to each slice. The slice is written into the circular memory when the next burst starts.

When a level-1 accept pulse arrives, the block records the current write position, minus a latency offset set at runtime, as the start of a readout window. The window length is also set at runtime. A small read engine copies that many consecutive slices, wrapping around the memory, into an output FIFO. An accept that arrives during a readout waits in a short queue. The output FIFO accepts back-pressure.

A build-time switch removes the whole function. When it is off, the outputs stay idle.

Top module: `cand_slice_buf`

## Requirements
- R1: A slice is 209 bits. Bits 191:0 hold retained word i at bits 32*i+31:32*i, for i = 0..5. Bits 197:192 hold the valid flag of word i at bit 192+i. Bits 201:198 are the error field. Bits 208:202 are the crossing number. The seventh word and its valid flag appear nowhere. Word positions not delivered in a burst read as zero with their valid flag clear.
- R2: A burst starts with a word presented with `in_sob` high. The slice assembled from a burst is stored when the next burst starts. Slices are stored at consecutive addresses starting at 0 after reset, modulo 128, and the crossing-number field equals the storage address.
- R3: Error bit 198 is set when the burst had fewer than 7 words, and error bit 199 is set when it had more than 7 words. Error bits 201:200 are zero.
- R4: An accept is captured in any cycle without a burst start. It reads N consecutive slices starting at the write address minus `lat_ofs`, modulo 128. N is `win_len`, with 0 treated as 1 and values above 5 treated as 5. Slices leave in address order, across the wrap from 127 to 0.
- R5: Accepts wait in a queue of 4 entries and are served in arrival order. An accept that finds the queue full is dropped and sets `acc_ovf`, which stays set until reset.
- R6: While `out_ready` is low, `out_valid` and `out_data` hold. The read engine waits when the output FIFO is full, and no slice is lost or repeated.
- R7: After reset, `out_valid` and `acc_ovf` are low.
- R8: With the enable parameter at 0, `out_valid` and `acc_ovf` stay low whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_act | input | 1 | A serial candidate word is present |
| in_sob | input | 1 | First word of a burst |
| in_word | input | 32 | Candidate word |
| in_vld | input | 1 | Valid flag of the candidate word |
| l1a | input | 1 | Level-1 accept pulse |
| lat_ofs | input | 7 | Readout start offset behind the write address |
| win_len | input | 3 | Number of slices per readout |
| out_ready | input | 1 | Consumer takes a slice |
| out_valid | output | 1 | Output FIFO holds a slice |
| out_data | output | 209 | Slice at the head of the output FIFO |
| acc_ovf | output | 1 | Sticky accept-queue overflow flag |

## Verification
Full 7-word bursts with random words and random valid flags are paired with several offset and window settings. This shows that each word lands in its own field and that the window is taken from the right start address. Window lengths of 0 and 7 check the clamping. Bursts of 5 and 9 words tell a short burst apart from a long one and from a correct one. An accept placed two slices after the address wrap checks that reads follow the wrap in order. Holding the consumer off separates a stall from a loss. Six accepts in six cycles separate the four that are queued and the one taken at once from the one that is dropped.

// File: rtl/cand_slice_pkg.sv
package cand_slice_pkg;
  parameter int WORD_W  = 32;
  parameter int KEEP    = 6;
  parameter int BCN_W   = 7;
  parameter int ERR_W   = 4;
  parameter int WIN_W   = 3;
  localparam int DATA_W  = KEEP * WORD_W;
  localparam int SLICE_W = BCN_W + ERR_W + KEEP + DATA_W;
  localparam int RING_D  = 1 << BCN_W;

  typedef enum logic [1:0] {RS_IDLE, RS_FETCH, RS_PUSH} rd_state_e;
endpackage

// File: rtl/burst_packer.sv
module burst_packer
  import cand_slice_pkg::*;
#(
  parameter int BURST_LEN = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_act,
  input  logic               in_sob,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               in_vld,
  output logic               wr_en,
  output logic [BCN_W-1:0]   wr_ptr,
  output logic [SLICE_W-1:0] wr_slice
);
  localparam int CNT_W = $clog2(BURST_LEN + 1) + 1;

  logic [DATA_W-1:0] dat_q, dat_d;
  logic [KEEP-1:0]   vld_q, vld_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              run_q, run_d;
  logic [BCN_W-1:0]  ptr_q, ptr_d;
  logic              too_short, too_long;

  assign too_short = cnt_q < CNT_W'(BURST_LEN);
  assign too_long  = cnt_q > CNT_W'(BURST_LEN);
  assign wr_en     = in_act && in_sob && run_q;
  assign wr_ptr    = ptr_q;
  assign wr_slice  = {ptr_q, {(ERR_W-2){1'b0}}, too_long, too_short, vld_q, dat_q};

  always_comb begin
    dat_d = dat_q;
    vld_d = vld_q;
    cnt_d = cnt_q;
    run_d = run_q;
    ptr_d = wr_en ? ptr_q + 1'b1 : ptr_q;
    if (in_act) begin
      if (in_sob) begin
        dat_d = '0;
        vld_d = '0;
        dat_d[WORD_W-1:0] = in_word;
        vld_d[0] = in_vld;
        cnt_d = CNT_W'(1);
        run_d = 1'b1;
      end else if (run_q) begin
        for (int i = 0; i < KEEP; i++) begin
          if (cnt_q == CNT_W'(i)) begin
            dat_d[i*WORD_W +: WORD_W] = in_word;
            vld_d[i] = in_vld;
          end
        end
        if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      dat_q <= dat_d;
      vld_q <= vld_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/slice_ring.sv
module slice_ring #(
  parameter int W     = 209,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         do_push, do_pop;

  assign empty   = wp_q == rp_q;
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = do_push ? wp_q + 1'b1 : wp_q;
    rp_d = do_pop  ? rp_q + 1'b1 : rp_q;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end
endmodule

// File: rtl/rd_engine.sv
module rd_engine
  import cand_slice_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [BCN_W-1:0] q_start,
  input  logic [WIN_W-1:0] q_win,
  output logic             q_pop,
  output logic             rd_en,
  output logic [BCN_W-1:0] rd_addr,
  input  logic             of_full,
  output logic             of_push
);
  rd_state_e        st_q, st_d;
  logic [BCN_W-1:0] addr_q, addr_d;
  logic [WIN_W-1:0] rem_q, rem_d;

  assign rd_addr = addr_q;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    q_pop   = 1'b0;
    rd_en   = 1'b0;
    of_push = 1'b0;
    case (st_q)
      RS_IDLE: if (!q_empty) begin
        q_pop  = 1'b1;
        addr_d = q_start;
        rem_d  = q_win;
        st_d   = RS_FETCH;
      end
      RS_FETCH: begin
        rd_en = 1'b1;
        st_d  = RS_PUSH;
      end
      RS_PUSH: if (!of_full) begin
        of_push = 1'b1;
        if (rem_q == WIN_W'(1)) begin
          st_d = RS_IDLE;
        end else begin
          addr_d = addr_q + 1'b1;
          rem_d  = rem_q - 1'b1;
          st_d   = RS_FETCH;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/cand_slice_buf.sv
module cand_slice_buf
  import cand_slice_pkg::*;
#(
  parameter bit ENABLE    = 1'b1,
  parameter int BURST_LEN = 7,
  parameter int MAX_WIN   = 5,
  parameter int AQ_DEPTH  = 4,
  parameter int OF_DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_act,
  input  logic               in_sob,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               in_vld,
  input  logic               l1a,
  input  logic [BCN_W-1:0]   lat_ofs,
  input  logic [WIN_W-1:0]   win_len,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [SLICE_W-1:0] out_data,
  output logic               acc_ovf
);
  localparam int AQ_W = BCN_W + WIN_W;

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  if (ENABLE) begin : g_on
    logic               wr_en;
    logic [BCN_W-1:0]   wr_ptr, start_addr, q_start, rd_addr;
    logic [SLICE_W-1:0] wr_slice, rd_data;
    logic [WIN_W-1:0]   win_eff, q_win;
    logic               aq_push, aq_empty, aq_full, q_pop, rd_en;
    logic               of_push, of_full, of_empty;
    logic               ovf_q, ovf_d;

    burst_packer #(.BURST_LEN(BURST_LEN)) u_pack (
      .clk(clk), .rst_n(srst_n), .in_act(in_act), .in_sob(in_sob),
      .in_word(in_word), .in_vld(in_vld),
      .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_slice(wr_slice)
    );

    slice_ring #(.W(SLICE_W), .DEPTH(RING_D)) u_ring (
      .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(wr_slice),
      .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

    always_comb begin
      if (win_len == '0)                     win_eff = WIN_W'(1);
      else if (win_len > WIN_W'(MAX_WIN))    win_eff = WIN_W'(MAX_WIN);
      else                                   win_eff = win_len;
      start_addr = wr_ptr - lat_ofs;
      aq_push    = l1a && !aq_full;
      ovf_d      = ovf_q || (l1a && aq_full);
    end

    sync_fifo #(.W(AQ_W), .DEPTH(AQ_DEPTH)) u_accq (
      .clk(clk), .rst_n(srst_n), .push(aq_push), .wdata({start_addr, win_eff}),
      .pop(q_pop), .rdata({q_start, q_win}), .empty(aq_empty), .full(aq_full)
    );

    rd_engine u_rd (
      .clk(clk), .rst_n(srst_n), .q_empty(aq_empty), .q_start(q_start),
      .q_win(q_win), .q_pop(q_pop), .rd_en(rd_en), .rd_addr(rd_addr),
      .of_full(of_full), .of_push(of_push)
    );

    sync_fifo #(.W(SLICE_W), .DEPTH(OF_DEPTH)) u_outq (
      .clk(clk), .rst_n(srst_n), .push(of_push), .wdata(rd_data),
      .pop(out_ready), .rdata(out_data), .empty(of_empty), .full(of_full)
    );

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) ovf_q <= 1'b0;
      else         ovf_q <= ovf_d;
    end

    assign out_valid = !of_empty;
    assign acc_ovf   = ovf_q;
  end else begin : g_off
    logic unused_inputs;
    assign unused_inputs = ^{in_act, in_sob, in_word, in_vld, l1a, lat_ofs,
                             win_len, out_ready, srst_n};
    assign out_valid = 1'b0;
    assign out_data  = '0;
    assign acc_ovf   = 1'b0;
  end
endmodule

module cand_slice_buf_chk
  import cand_slice_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l1a,
  input logic               out_ready,
  input logic               out_valid,
  input logic [SLICE_W-1:0] out_data,
  input logic               acc_ovf
);
  // R6: a slice offered but not taken stays on the output unchanged
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5: the overflow flag never clears once set
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ovf |=> acc_ovf);

  // R5: overflow rises only right after an accept
  a_r5_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_ovf) |-> $past(l1a));

  if (!ENABLE) begin : g_off_chk
    // R8: disabled build stays idle
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid && !acc_ovf);
  end else begin : g_on_chk
    // R7: nothing is offered in the first cycle after reset release
    a_r7_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid && !acc_ovf);
  end
endmodule

bind cand_slice_buf cand_slice_buf_chk #(.ENABLE(ENABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .l1a(l1a), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .acc_ovf(acc_ovf)
);

// File: tb/cand_slice_buf_tb_top.sv
module cand_slice_buf_tb_top;
  import cand_slice_pkg::*;
  localparam int CLK_P = 10;
  localparam int NTBL  = 5;
  // entry: {lat_ofs[17:11], win_len[10:8], bursts[7:0]}
  localparam logic [17:0] TBL [NTBL] = '{
    {7'd3, 3'd3, 8'd5},
    {7'd5, 3'd5, 8'd10},
    {7'd1, 3'd1, 8'd2},
    {7'd2, 3'd0, 8'd3},
    {7'd6, 3'd7, 8'd4}
  };

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic               rst_n, in_act, in_sob, in_vld, l1a, out_ready;
  logic [WORD_W-1:0]  in_word;
  logic [BCN_W-1:0]   lat_ofs;
  logic [WIN_W-1:0]   win_len;
  logic               out_valid, acc_ovf, off_valid, off_ovf;
  logic [SLICE_W-1:0] out_data, off_data;

  cand_slice_buf dut_i (
    .clk(clk), .rst_n(rst_n), .in_act(in_act), .in_sob(in_sob), .in_word(in_word),
    .in_vld(in_vld), .l1a(l1a), .lat_ofs(lat_ofs), .win_len(win_len),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .acc_ovf(acc_ovf)
  );

  cand_slice_buf #(.ENABLE(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .in_act(in_act), .in_sob(in_sob), .in_word(in_word),
    .in_vld(in_vld), .l1a(l1a), .lat_ofs(lat_ofs), .win_len(win_len),
    .out_ready(out_ready), .out_valid(off_valid), .out_data(off_data), .acc_ovf(off_ovf)
  );

  logic [SLICE_W-1:0] mdl  [RING_D];
  logic [SLICE_W-1:0] rx   [1024];
  logic [SLICE_W-1:0] expq [1024];
  int rx_n = 0, exp_n = 0, errors = 0, checks = 0;
  bit done = 1'b0, started = 1'b0;
  logic [BCN_W-1:0]  nc = '0;
  logic [DATA_W-1:0] p_dat;
  logic [KEEP-1:0]   p_vld;
  int                p_len;

  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (out_valid && out_ready && rx_n < 1024) begin
      rx[rx_n] = out_data;
      rx_n = rx_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [SLICE_W-1:0] act,
                     input logic [SLICE_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic commit_pending();
    if (started) begin
      mdl[nc] = {nc, 2'b00, p_len > 7, p_len < 7, p_vld, p_dat};
      nc = nc + 1'b1;
    end
  endtask

  task automatic burst(input int len);
    for (int w = 0; w < len; w++) begin
      @(negedge clk);
      in_act  = 1'b1;
      in_sob  = (w == 0);
      in_word = $urandom;
      in_vld  = 1'($urandom);
      if (w == 0) begin
        commit_pending();
        started = 1'b1;
        p_dat = '0;
        p_vld = '0;
        p_len = 0;
      end
      if (w < KEEP) begin
        p_dat[w*WORD_W +: WORD_W] = in_word;
        p_vld[w] = in_vld;
      end
      p_len++;
    end
    @(negedge clk);
    in_act = 1'b0;
    in_sob = 1'b0;
  endtask

  task automatic expect_win(input logic [6:0] lat, input logic [2:0] win);
    int n;
    logic [BCN_W-1:0] a;
    n = (win == 0) ? 1 : (win > 5) ? 5 : int'(win);
    a = nc - lat;
    for (int i = 0; i < n; i++) begin
      expq[exp_n] = mdl[a];
      exp_n++;
      a = a + 1'b1;
    end
  endtask

  task automatic accept(input logic [6:0] lat, input logic [2:0] win);
    @(negedge clk);
    l1a = 1'b1;
    lat_ofs = lat;
    win_len = win;
    @(negedge clk);
    l1a = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    for (int t = 0; t < 3000 && rx_n < target; t++) @(negedge clk);
    #(CLK_P/2);
  endtask

  task automatic compare_from(input int from, input string tag);
    chk(rx_n == exp_n, {tag, " beat count"}, SLICE_W'(rx_n), SLICE_W'(exp_n));
    for (int k = from; k < exp_n; k++) chk(rx[k] === expq[k], tag, rx[k], expq[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    logic [SLICE_W-1:0] held;
    rst_n = 1'b0; in_act = 1'b0; in_sob = 1'b0; in_word = '0; in_vld = 1'b0;
    l1a = 1'b0; lat_ofs = '0; win_len = '0; out_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #(CLK_P/4);
    chk(!out_valid, "R7 out_valid after reset", SLICE_W'(out_valid), '0);
    chk(!acc_ovf, "R7 acc_ovf after reset", SLICE_W'(acc_ovf), '0);

    // R1 R4: table of offsets and windows over full bursts, clamping included
    for (int e = 0; e < NTBL; e++) begin
      for (int b = 0; b < int'(TBL[e][7:0]); b++) burst(7);
      base = exp_n;
      expect_win(TBL[e][17:11], TBL[e][10:8]);
      accept(TBL[e][17:11], TBL[e][10:8]);
      wait_rx(exp_n);
      compare_from(base, "R1 R4 window");
    end

    // R3: short and long bursts
    burst(5); burst(9); burst(7); burst(7);
    base = exp_n;
    expect_win(7'd3, 3'd3);
    accept(7'd3, 3'd3);
    wait_rx(exp_n);
    compare_from(base, "R3 burst length");
    chk(rx[base][201:198] === 4'b0001, "R3 short error bits", SLICE_W'(rx[base][201:198]), SLICE_W'(1));
    chk(rx[base+1][201:198] === 4'b0010, "R3 long error bits", SLICE_W'(rx[base+1][201:198]), SLICE_W'(2));
    chk(rx[base+2][201:198] === 4'b0000, "R3 clean error bits", SLICE_W'(rx[base+2][201:198]), '0);

    // R2: wrap of the address
    while (nc != 7'd2) burst(7);
    base = exp_n;
    expect_win(7'd3, 3'd3);
    accept(7'd3, 3'd3);
    wait_rx(exp_n);
    compare_from(base, "R2 R4 wrap");
    chk(rx[base][208:202] === 7'd127, "R2 crossing field at wrap", SLICE_W'(rx[base][208:202]), SLICE_W'(127));
    chk(rx[base+1][208:202] === 7'd0, "R2 crossing field after wrap", SLICE_W'(rx[base+1][208:202]), '0);

    // R6: stall with a full output FIFO
    burst(7); burst(7);
    out_ready = 1'b0;
    base = exp_n;
    expect_win(7'd5, 3'd5);
    accept(7'd5, 3'd5);
    repeat (30) @(negedge clk);
    #(CLK_P/4);
    held = out_data;
    chk(out_valid, "R6 valid while stalled", SLICE_W'(out_valid), SLICE_W'(1));
    chk(rx_n == base, "R6 no beat while stalled", SLICE_W'(rx_n), SLICE_W'(base));
    repeat (5) @(negedge clk);
    #(CLK_P/4);
    chk(out_data === held, "R6 data held", out_data, held);
    @(negedge clk);
    out_ready = 1'b1;
    wait_rx(exp_n);
    compare_from(base, "R6 after stall");

    // R5: six accepts in a row, the last one dropped
    chk(!acc_ovf, "R5 no overflow before burst of accepts", SLICE_W'(acc_ovf), '0);
    base = exp_n;
    for (int i = 0; i < 5; i++) expect_win(7'd5, 3'd5);
    @(negedge clk);
    l1a = 1'b1; lat_ofs = 7'd5; win_len = 3'd5;
    repeat (6) @(negedge clk);
    l1a = 1'b0;
    wait_rx(exp_n);
    repeat (60) @(negedge clk);
    #(CLK_P/4);
    compare_from(base, "R5 queued accepts");
    chk(acc_ovf, "R5 overflow flag", SLICE_W'(acc_ovf), SLICE_W'(1));

    // R8: disabled build stayed idle throughout
    chk(!off_valid && !off_ovf, "R8 disabled idle", SLICE_W'({off_valid, off_ovf}), '0);
    chk(off_data === '0, "R8 disabled data", off_data, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule